// File: doc/BRIEF.md
# Burst column address sequencer

This block sits in the command path of a double-data-rate SDRAM model. It keeps the device mode word, which is written by a mode-load command. From that word it takes the burst length and the burst ordering, and it turns every read or write command into a stream of column addresses, one for each data beat.

Each burst stays inside an aligned group of columns whose size equals the programmed burst length. The column bits above the low one, two or three bits pick the group. The low bits pick the first beat, and the sequence wraps at the group edge. The beats can advance in counting order or in exclusive-or order.

A mode load is refused, and flagged, while any bank is open. After a successful load the block holds off reads and writes for a fixed number of cycles. A read or write issued while the stored length code is reserved is flagged and produces no beats. A read or write accepted while a burst is still running cuts that burst short and starts the new one.

Top module: `burst_col_seq`

## Requirements
- R1: Commands use cmd_op 0 = idle, 1 = mode load, 2 = read, 3 = write. A mode load with cmd_bank equal to 0 and banks_idle high copies cmd_addr into mode_q, visible in the cycle after the command. A mode load with any cmd_bank bit set changes nothing.
- R2: In mode_q, bits [2:0] are the length code (1 gives 2 beats, 2 gives 4, 3 gives 8, all other codes are reserved) and bit 3 selects the order (0 counting, 1 exclusive-or). Bits [6:4] hold the latency and bits [11:7] the operating mode, both kept as written.
- R3: mode_q bit 8 reads 1 for exactly one cycle after a load that sets it and 0 afterwards. All other bits keep their value until the next load.
- R4: A mode load with cmd_bank 0 while banks_idle is low raises err_load for one cycle in the cycle after the command, leaves mode_q unchanged apart from the bit-8 clear, and does not start the hold-off.
- R5: After a successful load, busy is high for MRD_CYCLES cycles, starting in the cycle after the load. A read or write sampled while busy is high produces no beats and no error.
- R6: An accepted read or write gives beat 0 with col_addr equal to the command column in the cycle after the command, then one beat per cycle for the programmed length. col_last is set on the final beat only, and col_is_wr is 1 for a write and 0 for a read.
- R7: In counting order, the low log2(length) bits of beat k equal (start + k) modulo the length.
- R8: In exclusive-or order, the low log2(length) bits of beat k equal start XOR k.
- R9: Every beat keeps the column bits above the low log2(length) bits equal to those of the start column, so the burst wraps inside its aligned group.
- R10: A read or write while not busy and with a reserved length code raises err_len for one cycle in the cycle after the command. It produces no beats and leaves a running burst untouched.
- R11: A read or write accepted while a burst is running ends that burst. The new beat 0 appears in the next cycle.
- R12: After reset, mode_q is 0, col_valid, col_last, busy, err_load and err_len are low, and a read then raises err_len because length code 0 is reserved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cmd_op | input | 2 | Command: 0 idle, 1 mode load, 2 read, 3 write |
| cmd_bank | input | 2 | Bank select; a mode load acts only when it is 0 |
| cmd_addr | input | ADDR_W | Mode word for a load, start column (low COL_W bits) for read or write |
| banks_idle | input | 1 | High when no bank is open |
| mode_q | output | ADDR_W | Stored mode word |
| busy | output | 1 | Hold-off after a mode load |
| err_load | output | 1 | One-cycle flag: mode load refused |
| err_len | output | 1 | One-cycle flag: read or write with reserved length |
| col_valid | output | 1 | A beat address is present |
| col_addr | output | COL_W | Column address of the beat |
| col_last | output | 1 | Final beat of the burst |
| col_is_wr | output | 1 | Burst belongs to a write |

## Verification
Every result is due one rising edge after the command that causes it. This covers the mode word, busy, both error flags and beat 0. Beat k follows k cycles after beat 0, and busy falls MRD_CYCLES edges after the load. The bench keeps a behavioural model that updates at each rising edge from the inputs sampled there, holding the expected beats in a queue. It compares every output against the model at the following falling edge, so each result is checked in exactly the cycle in which it is due. Directed checks add the reset state, the single-cycle life of mode bit 8 and the stored latency and operating-mode fields.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_MRS  = 2'd1,
    OP_RD   = 2'd2,
    OP_WR   = 2'd3
  } bcs_op_e;

  localparam int LEN_LSB    = 0;
  localparam int LEN_BITS   = 3;
  localparam int ORDER_BIT  = 3;
  localparam int SELFCLR_BIT = 8;
  localparam int IDX_BITS   = 3;   // log2 of the longest burst

  function automatic logic len_code_ok(input logic [LEN_BITS-1:0] code);
    return (code == 3'd1) || (code == 3'd2) || (code == 3'd3);
  endfunction

  function automatic logic [IDX_BITS-1:0] len_mask(input logic [LEN_BITS-1:0] code);
    logic [IDX_BITS-1:0] m;
    case (code)
      3'd1:    m = 3'b001;
      3'd2:    m = 3'b011;
      3'd3:    m = 3'b111;
      default: m = 3'b000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg #(
  parameter int ADDR_W     = 12,
  parameter int MRD_CYCLES = 3,
  parameter int SC_BIT     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_req,
  input  logic              banks_idle,
  input  logic [ADDR_W-1:0] load_data,
  output logic [ADDR_W-1:0] mode_q,
  output logic              busy,
  output logic              err_load
);

  localparam int CNT_W = $clog2(MRD_CYCLES + 1);

  logic [CNT_W-1:0] hold_cnt;
  logic             load_ok;

  assign load_ok = load_req && banks_idle;
  assign busy    = (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= '0;
      hold_cnt <= '0;
      err_load <= 1'b0;
    end else begin
      err_load <= load_req && !banks_idle;
      if (load_ok) begin
        mode_q   <= load_data;
        hold_cnt <= CNT_W'(MRD_CYCLES);
      end else begin
        mode_q[SC_BIT] <= 1'b0;
        if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
      end
    end
  end

  // R3: the self-clearing bit lives for one cycle unless reloaded
  assert_selfclear_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q[SC_BIT] && !load_ok) |=> !mode_q[SC_BIT]);

  // R4: a refused load leaves the other mode bits alone
  assert_refused_hold_R4: assert property (@(posedge clk) disable iff (rst)
    err_load |-> ((mode_q ^ $past(mode_q)) & ~(ADDR_W'(1) << SC_BIT)) == '0);

  // R5: hold-off starts right after a good load
  assert_busy_after_load_R5: assert property (@(posedge clk) disable iff (rst)
    load_ok |=> busy);

endmodule

// File: rtl/bcs_beat_gen.sv
module bcs_beat_gen #(
  parameter int COL_W = 10,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [COL_W-1:0] start_col,
  input  logic             start_wr,
  input  logic             start_ilv,
  input  logic [IDX_W-1:0] start_mask,
  output logic             col_valid,
  output logic [COL_W-1:0] col_addr,
  output logic             col_last,
  output logic             col_is_wr,
  output logic             beat_first
);

  localparam int HI_W = COL_W - IDX_W;

  logic             act_q;
  logic             ilv_q;
  logic [IDX_W-1:0] idx_q;
  logic [IDX_W-1:0] mask_q;
  logic [COL_W-1:0] base_q;
  logic [IDX_W-1:0] low_raw;
  logic [COL_W-1:0] mask_ext;
  logic [COL_W-1:0] nxt_addr;

  assign mask_ext = {{HI_W{1'b0}}, mask_q};
  assign low_raw  = ilv_q ? (base_q[IDX_W-1:0] ^ idx_q)
                          : (base_q[IDX_W-1:0] + idx_q);
  assign nxt_addr = (base_q & ~mask_ext) | {{HI_W{1'b0}}, (low_raw & mask_q)};

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q      <= 1'b0;
      ilv_q      <= 1'b0;
      idx_q      <= '0;
      mask_q     <= '0;
      base_q     <= '0;
      col_valid  <= 1'b0;
      col_addr   <= '0;
      col_last   <= 1'b0;
      col_is_wr  <= 1'b0;
      beat_first <= 1'b0;
    end else if (start) begin
      base_q     <= start_col;
      mask_q     <= start_mask;
      ilv_q      <= start_ilv;
      idx_q      <= IDX_W'(1);
      act_q      <= 1'b1;
      col_valid  <= 1'b1;
      col_addr   <= start_col;
      col_last   <= 1'b0;
      col_is_wr  <= start_wr;
      beat_first <= 1'b1;
    end else if (act_q) begin
      col_valid  <= 1'b1;
      col_addr   <= nxt_addr;
      col_last   <= (idx_q == mask_q);
      beat_first <= 1'b0;
      idx_q      <= idx_q + 1'b1;
      if (idx_q == mask_q) act_q <= 1'b0;
    end else begin
      col_valid  <= 1'b0;
      col_last   <= 1'b0;
      beat_first <= 1'b0;
    end
  end

  // R6: last marks a real beat
  assert_last_valid_R6: assert property (@(posedge clk) disable iff (rst)
    col_last |-> col_valid);

  // R9: upper column bits never move inside one burst
  assert_block_wrap_R9: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !beat_first) |-> ((col_addr ^ $past(col_addr)) & ~mask_ext) == '0);

  // R7: counting order advances the low bits by one, modulo the length
  assert_seq_step_R7: assert property (@(posedge clk) disable iff (rst)
    (col_valid && !beat_first && !ilv_q) |->
      ((col_addr[IDX_W-1:0] - $past(col_addr[IDX_W-1:0])) & mask_q) == (IDX_W'(1) & mask_q));

  // R11: an accepted command yields its first beat at once
  assert_start_beat_R11: assert property (@(posedge clk) disable iff (rst)
    start |=> (beat_first && col_valid && col_addr == $past(start_col)));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int ADDR_W     = 12,
  parameter int COL_W      = 10,
  parameter int MRD_CYCLES = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cmd_op,
  input  logic [1:0]        cmd_bank,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              banks_idle,
  output logic [ADDR_W-1:0] mode_q,
  output logic              busy,
  output logic              err_load,
  output logic              err_len,
  output logic              col_valid,
  output logic [COL_W-1:0]  col_addr,
  output logic              col_last,
  output logic              col_is_wr
);
  import bcs_pkg::*;

  localparam int IDX_W = IDX_BITS;

  bcs_op_e              op;
  logic                 mrs_req;
  logic                 is_rdwr;
  logic                 len_ok;
  logic                 accept;
  logic                 beat_first;
  logic [LEN_BITS-1:0]  len_code;

  assign op       = bcs_op_e'(cmd_op);
  assign mrs_req  = (op == OP_MRS) && (cmd_bank == 2'b00);
  assign is_rdwr  = (op == OP_RD) || (op == OP_WR);
  assign len_code = mode_q[LEN_LSB +: LEN_BITS];
  assign len_ok   = len_code_ok(len_code);
  assign accept   = is_rdwr && !busy && len_ok;

  bcs_mode_reg #(
    .ADDR_W     (ADDR_W),
    .MRD_CYCLES (MRD_CYCLES),
    .SC_BIT     (SELFCLR_BIT)
  ) i_mode (
    .clk        (clk),
    .rst        (rst),
    .load_req   (mrs_req),
    .banks_idle (banks_idle),
    .load_data  (cmd_addr),
    .mode_q     (mode_q),
    .busy       (busy),
    .err_load   (err_load)
  );

  bcs_beat_gen #(
    .COL_W (COL_W),
    .IDX_W (IDX_W)
  ) i_beats (
    .clk        (clk),
    .rst        (rst),
    .start      (accept),
    .start_col  (cmd_addr[COL_W-1:0]),
    .start_wr   (op == OP_WR),
    .start_ilv  (mode_q[ORDER_BIT]),
    .start_mask (len_mask(len_code)),
    .col_valid  (col_valid),
    .col_addr   (col_addr),
    .col_last   (col_last),
    .col_is_wr  (col_is_wr),
    .beat_first (beat_first)
  );

  always_ff @(posedge clk) begin
    if (rst) err_len <= 1'b0;
    else     err_len <= is_rdwr && !busy && !len_ok;
  end

  // R5: no burst starts from a command seen during the hold-off
  assert_busy_blocks_R5: assert property (@(posedge clk) disable iff (rst)
    (is_rdwr && busy) |=> !beat_first);

  // R10: a reserved length never starts a burst
  assert_reserved_nobeat_R10: assert property (@(posedge clk) disable iff (rst)
    err_len |-> !beat_first);

  // R4: refused load and hold-off start never coincide
  assert_refused_no_busy_R4: assert property (@(posedge clk) disable iff (rst)
    (mrs_req && !banks_idle && !busy) |=> !busy);

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int ADDR_W = 12;
  localparam int COL_W  = 10;
  localparam int MRD    = 3;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [1:0]        op = 2'd0;
  logic [1:0]        bank = 2'd0;
  logic [ADDR_W-1:0] addr = '0;
  logic              idle_in = 1'b1;
  logic [ADDR_W-1:0] mode_q;
  logic              busy, err_load, err_len, col_valid, col_last, col_is_wr;
  logic [COL_W-1:0]  col_addr;

  burst_col_seq #(.ADDR_W(ADDR_W), .COL_W(COL_W), .MRD_CYCLES(MRD)) i_burst_col_seq (
    .clk(clk), .rst(rst), .cmd_op(op), .cmd_bank(bank), .cmd_addr(addr),
    .banks_idle(idle_in), .mode_q(mode_q), .busy(busy), .err_load(err_load),
    .err_len(err_len), .col_valid(col_valid), .col_addr(col_addr),
    .col_last(col_last), .col_is_wr(col_is_wr)
  );

  always #10 clk = ~clk;

  int    checks = 0;
  int    errors = 0;
  string tag = "R6";
  bit    run = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic [ADDR_W-1:0] m_mode;
  int  m_cnt;
  int  q[$];
  bit  m_v, m_last, m_wr, m_curwr, m_errl, m_errn;
  int  m_a;

  always @(posedge clk) begin
    bit bz;
    int c, bl, s, lo;
    if (rst) begin
      m_mode = '0; m_cnt = 0; q.delete();
      m_v = 0; m_last = 0; m_wr = 0; m_curwr = 0; m_errl = 0; m_errn = 0; m_a = 0;
    end else begin
      bz = (m_cnt != 0);
      m_errl = 0; m_errn = 0;
      if (op == 2'd1 && bank == 2'd0 && idle_in) begin
        m_mode = addr; m_cnt = MRD;
      end else begin
        m_mode[8] = 1'b0;
        if (m_cnt > 0) m_cnt--;
        if (op == 2'd1 && bank == 2'd0) m_errl = 1;
      end
      if (op >= 2'd2 && !bz) begin
        c = int'(m_mode[2:0]);
        if (c >= 1 && c <= 3) begin
          bl = 1 << c;
          s = int'(addr[COL_W-1:0]);
          q.delete();
          for (int k = 0; k < bl; k++) begin
            lo = m_mode[3] ? ((s ^ k) & (bl - 1)) : ((s + k) % bl);
            q.push_back((s & ~(bl - 1)) | lo);
          end
          m_curwr = (op == 2'd3);
        end else m_errn = 1;
      end
      if (q.size() > 0) begin
        m_v = 1; m_a = q.pop_front(); m_last = (q.size() == 0); m_wr = m_curwr;
      end else begin
        m_v = 0; m_last = 0;
      end
    end
  end

  always @(negedge clk) begin
    if (run && !rst) begin
      chk(mode_q == m_mode, "R1", "mode_q", int'(mode_q), int'(m_mode));
      chk(busy == (m_cnt != 0), "R5", "busy", int'(busy), int'(m_cnt != 0));
      chk(err_load == m_errl, "R4", "err_load", int'(err_load), int'(m_errl));
      chk(err_len == m_errn, "R10", "err_len", int'(err_len), int'(m_errn));
      chk(col_valid == m_v, tag, "col_valid", int'(col_valid), int'(m_v));
      chk(col_last == m_last, "R6", "col_last", int'(col_last), int'(m_last));
      if (m_v) begin
        chk(int'(col_addr) == m_a, tag, "col_addr", int'(col_addr), m_a);
        chk(col_is_wr == m_wr, "R6", "col_is_wr", int'(col_is_wr), int'(m_wr));
      end
    end
  end

  task automatic cmd(input logic [1:0] o, input logic [1:0] b, input logic [ADDR_W-1:0] a);
    @(negedge clk);
    op = o; bank = b; addr = a;
    @(negedge clk);
    op = 2'd0; bank = 2'd0; addr = '0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12: reset state
    chk(mode_q == '0, "R12", "mode_q", int'(mode_q), 0);
    chk(!col_valid && !col_last, "R12", "col_valid", int'(col_valid), 0);
    chk(!busy && !err_load && !err_len, "R12", "flags", int'({busy, err_load, err_len}), 0);
    run = 1;
    tag = "R12";
    cmd(2'd2, 2'd0, 12'h010);              // reserved code 0 after reset
    wait_cyc(2);

    tag = "R1";
    cmd(2'd1, 2'd1, 12'h032);              // bank bit set: ignored
    wait_cyc(1);
    chk(mode_q == '0, "R1", "mode_q after bank!=0", int'(mode_q), 0);

    tag = "R4";
    idle_in = 1'b0;
    cmd(2'd1, 2'd0, 12'h032);              // refused: banks open
    idle_in = 1'b1;
    wait_cyc(1);

    // counting, 4 beats, latency 2, bit 8 set
    tag = "R3";
    cmd(2'd1, 2'd0, 12'h122);
    chk(mode_q[8] == 1'b1, "R3", "bit8 first cycle", int'(mode_q[8]), 1);
    chk(mode_q[6:4] == 3'd2, "R2", "latency field", int'(mode_q[6:4]), 2);
    @(negedge clk);
    chk(mode_q[8] == 1'b0, "R3", "bit8 cleared", int'(mode_q[8]), 0);
    tag = "R5";
    cmd(2'd2, 2'd0, 12'h1F6);              // during hold-off: ignored
    wait_cyc(3);

    tag = "R7";
    cmd(2'd2, 2'd0, 12'h1F6);
    wait_cyc(5);
    cmd(2'd3, 2'd0, 12'h07B);
    wait_cyc(5);

    // exclusive-or order, 8 beats, latency 5, op-mode bits set
    tag = "R8";
    cmd(2'd1, 2'd0, 12'hA5B);
    chk(mode_q[11:9] == 3'b101, "R2", "opmode field", int'(mode_q[11:9]), 5);
    chk(mode_q[3] == 1'b1, "R2", "order bit", int'(mode_q[3]), 1);
    wait_cyc(4);
    cmd(2'd2, 2'd0, 12'h2C5);
    wait_cyc(9);
    cmd(2'd3, 2'd0, 12'h3FE);
    wait_cyc(9);

    // counting, 2 beats, wrap at group edge
    tag = "R9";
    cmd(2'd1, 2'd0, 12'h031);
    wait_cyc(4);
    cmd(2'd2, 2'd0, 12'h0FF);
    wait_cyc(3);
    cmd(2'd3, 2'd0, 12'h200);
    wait_cyc(3);

    // abort: 8-beat burst cut by a new command
    tag = "R11";
    cmd(2'd1, 2'd0, 12'h003);
    wait_cyc(4);
    cmd(2'd2, 2'd0, 12'h13C);
    cmd(2'd3, 2'd0, 12'h245);
    wait_cyc(10);

    // reserved code while an older burst keeps running
    tag = "R10";
    cmd(2'd2, 2'd0, 12'h00A);
    cmd(2'd1, 2'd0, 12'h037);
    wait_cyc(2);
    cmd(2'd2, 2'd0, 12'h011);
    wait_cyc(10);
    cmd(2'd1, 2'd0, 12'h004);
    wait_cyc(4);
    cmd(2'd3, 2'd0, 12'h011);
    wait_cyc(4);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule